// File: doc/BRIEF.md
# Half-Rate Symmetric FIR Decimator

This block is a linear-phase low-pass FIR filter that halves the sample rate of a signed PCM stream. It sits after a comb decimation stage and flattens that stage's passband droop. It also removes the band that would alias when the rate drops. The taps are fixed through a parameter. Only the first half of the impulse response, plus the centre tap, is supplied, because the response is mirror-symmetric.

Samples are accepted on a valid/ready input port. Every second accepted sample starts one output computation. At that moment the newest 21 samples are held in a shift line. Mirrored pairs of samples are added first. A single shared multiplier then steps through the ten pair sums and the centre sample, one per clock. The sum is rounded to nearest and clamped to the 16-bit range. The result is presented on a valid/ready output port.

Back-pressure rules are as follows. The input port takes no sample while a computation is running. It also takes no pair-completing sample while an earlier result is still waiting on the output. The output holds its value until the consumer takes it. A sample offered while `in_ready` is low is not taken, and the upstream side keeps it.

Top module: `fir_dec2`

## Requirements
- R1: Each result equals the sum over k = 0..20 of h[k]·d[k], taken at the moment the result's computation starts. Here d[0] is the newest accepted sample and d[k] is the k-th older one. h[k] = h[20−k], and entry j of the coefficient parameter (bits [16j+15:16j]) gives h[j] for j = 0..10. Coefficients are signed with 15 fractional bits.
- R2: Exactly one result is produced for every two accepted samples. A computation starts on the second, fourth, sixth, … sample accepted after reset.
- R3: The full-precision sum is rounded by adding 2^14 and then shifting right arithmetically by 15 bits, so ties round toward plus infinity. A sum of +1087.5 gives 1088 and a sum of −1087.5 gives −1087.
- R4: A rounded value above 32767 is output as 32767. A rounded value below −32768 is output as −32768.
- R5: `out_valid` rises exactly 11 clock edges after the edge that accepted the pair-completing sample.
- R6: `in_ready` is low while a computation runs. It is also low when the next accepted sample would complete a pair and `out_valid` is still high. Otherwise it is high.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_data` do not change. A result is removed on the edge where both are high.
- R8: Reset zeroes the stored samples and clears the pairing phase. After reset `in_ready` is 1 and `out_valid` is 0, and the first result after reset uses the first two samples accepted after it, with zeros for all older positions.
- R9: An `in_valid` pulse while `in_ready` is low neither stores its data nor advances the pairing phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input sample offered |
| in_ready | output | 1 | Block can take an input sample |
| in_data | input | 16 | Signed input sample |
| out_valid | output | 1 | Filtered result available |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | 16 | Signed filtered, rounded and clamped result |

## Verification
The bench builds the block with its default parameters: 21 taps, 16-bit samples and the default droop-compensating coefficient set. That set has unequal, non-zero values on every unique tap, so a fault on any one pair or on the centre multiply shows up in the results. Single-sample impulses of ±2048 on the centre tap land exactly on a rounding tie in both directions. Full-scale random streams drive the sum past both clamp limits. A random consumer stall, together with junk offered while the input port is closed, exercises each back-pressure rule against the behavioural model.

// File: rtl/fir_dec2_pkg.sv
package fir_dec2_pkg;
  // position of the next accepted sample within its pair
  typedef enum logic {PH_FIRST = 1'b0, PH_SECOND = 1'b1} phase_e;
endpackage

// File: rtl/fir_dec2_line.sv
module fir_dec2_line #(
  parameter int DATA_W = 16,
  parameter int TAPS   = 21
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     shift_en,
  input  logic signed [DATA_W-1:0] din,
  output logic signed [DATA_W-1:0] taps_o [TAPS]
);
  logic signed [DATA_W-1:0] mem [TAPS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < TAPS; i++) mem[i] <= '0;
    end else if (shift_en) begin
      mem[0] <= din;
      for (int i = 1; i < TAPS; i++) mem[i] <= mem[i-1];
    end
  end

  assign taps_o = mem;
endmodule

// File: rtl/fir_dec2_fold.sv
module fir_dec2_fold #(
  parameter int DATA_W = 16,
  parameter int TAPS   = 21
) (
  input  logic signed [DATA_W-1:0] taps_i [TAPS],
  output logic signed [DATA_W:0]   ops_o  [(TAPS+1)/2]
);
  localparam int NPAIRS = (TAPS - 1) / 2;

  // mirrored samples share one coefficient: add them before the multiplier
  for (genvar p = 0; p < NPAIRS; p++) begin : g_pair
    assign ops_o[p] = {taps_i[p][DATA_W-1], taps_i[p]}
                    + {taps_i[TAPS-1-p][DATA_W-1], taps_i[TAPS-1-p]};
  end
  assign ops_o[NPAIRS] = {taps_i[NPAIRS][DATA_W-1], taps_i[NPAIRS]};
endmodule

// File: rtl/fir_dec2_mac.sv
module fir_dec2_mac #(
  parameter int                    DATA_W = 16,
  parameter int                    COEF_W = 16,
  parameter int                    FRAC   = 15,
  parameter int                    NOPS   = 11,
  parameter logic [NOPS*COEF_W-1:0] COEFS = '0
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic signed [DATA_W:0]   ops [NOPS],
  input  logic                     out_ready,
  output logic                     busy,
  output logic                     out_valid,
  output logic signed [DATA_W-1:0] out_data
);
  localparam int SUM_W  = DATA_W + 1;
  localparam int PROD_W = SUM_W + COEF_W;
  localparam int ACC_W  = PROD_W + $clog2(NOPS) + 1;
  localparam int STEP_W = $clog2(NOPS);
  localparam logic [STEP_W-1:0] LAST = STEP_W'(NOPS - 1);
  localparam logic signed [ACC_W-1:0] RND_HALF = ACC_W'(1) << (FRAC - 1);
  localparam logic signed [ACC_W-1:0] SAT_HI = ACC_W'((longint'(1) <<< (DATA_W - 1)) - 1);
  localparam logic signed [ACC_W-1:0] SAT_LO = ~SAT_HI;

  logic [STEP_W-1:0]        step;
  logic signed [ACC_W-1:0]  acc, acc_next, rnd, shifted;
  logic signed [SUM_W-1:0]  op_sel;
  logic signed [COEF_W-1:0] coef_sel;
  logic signed [PROD_W-1:0] prod;
  logic signed [DATA_W-1:0] sat_val;

  always_comb begin
    op_sel   = ops[step];
    coef_sel = COEFS[step*COEF_W +: COEF_W];
    prod     = PROD_W'(op_sel) * PROD_W'(coef_sel);
    acc_next = acc + ACC_W'(prod);
    rnd      = acc_next + RND_HALF;
    shifted  = rnd >>> FRAC;
    if (shifted > SAT_HI)      sat_val = SAT_HI[DATA_W-1:0];
    else if (shifted < SAT_LO) sat_val = SAT_LO[DATA_W-1:0];
    else                       sat_val = shifted[DATA_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      step      <= '0;
      acc       <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      if (out_valid && out_ready) out_valid <= 1'b0;
      if (start) begin
        busy <= 1'b1;
        step <= '0;
        acc  <= '0;
      end else if (busy) begin
        acc <= acc_next;
        if (step == LAST) begin
          busy      <= 1'b0;
          out_valid <= 1'b1;
          out_data  <= sat_val;
        end else begin
          step <= step + 1'b1;
        end
      end
    end
  end

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  // R5
  finish_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !start && step == LAST |=> out_valid && !busy);

  // R5
  valid_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(busy));
endmodule

// File: rtl/fir_dec2.sv
module fir_dec2
  import fir_dec2_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int COEF_W = 16,
  parameter int FRAC   = 15,
  parameter int TAPS   = 21,
  parameter logic [((TAPS+1)/2)*COEF_W-1:0] COEFS = {
    16'sd17400, 16'sd9750, -16'sd910, -16'sd2290, 16'sd640, 16'sd1012,
    -16'sd390, -16'sd410, 16'sd175, 16'sd118, -16'sd62}
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic signed [DATA_W-1:0] in_data,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic signed [DATA_W-1:0] out_data
);
  localparam int NOPS = (TAPS + 1) / 2;

  phase_e                   phase;
  logic                     accept, start, mac_busy;
  logic signed [DATA_W-1:0] taps [TAPS];
  logic signed [DATA_W:0]   ops  [NOPS];

  always_comb begin
    in_ready = !mac_busy && (phase == PH_FIRST || !out_valid);
    accept   = in_valid && in_ready;
    start    = accept && phase == PH_SECOND;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      phase <= PH_FIRST;
    else if (accept) phase <= (phase == PH_FIRST) ? PH_SECOND : PH_FIRST;
  end

  fir_dec2_line #(.DATA_W(DATA_W), .TAPS(TAPS)) i_line (
    .clk(clk), .rst_n(rst_n), .shift_en(accept), .din(in_data), .taps_o(taps));

  fir_dec2_fold #(.DATA_W(DATA_W), .TAPS(TAPS)) i_fold (
    .taps_i(taps), .ops_o(ops));

  fir_dec2_mac #(.DATA_W(DATA_W), .COEF_W(COEF_W), .FRAC(FRAC), .NOPS(NOPS),
                 .COEFS(COEFS)) i_mac (
    .clk(clk), .rst_n(rst_n), .start(start), .ops(ops), .out_ready(out_ready),
    .busy(mac_busy), .out_valid(out_valid), .out_data(out_data));

  // R2
  trig_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && phase == PH_SECOND |=> mac_busy);

  // R6
  no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !mac_busy && !out_valid);
endmodule

// File: tb/test_fir_dec2.sv
module test_fir_dec2;
  localparam int CLK_PERIOD = 10;
  localparam int TAPS = 21;
  localparam int NOPS = 11;
  localparam int H [NOPS] = '{-62, 118, 175, -410, -390, 1012, 640, -2290, -910, 9750, 17400};

  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0, out_ready = 1'b0;
  logic signed [15:0] in_data = '0;
  logic in_ready, out_valid;
  logic signed [15:0] out_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  fir_dec2 i_fir_dec2 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data));

  int n_chk = 0, n_fail = 0;
  int hist [TAPS];
  int m_phase, m_busy, m_pend, m_out;
  bit m_ov;
  int sat_hi = 0, sat_lo = 0;
  int got [$];
  bit rdy_mode = 0, stall_prev = 0, done = 0;
  int stall_data;
  bit [31:0] rs = 32'h1234_5678;

  function automatic bit [31:0] rnd();
    rs ^= rs << 13; rs ^= rs >> 17; rs ^= rs << 5;
    return rs;
  endfunction

  function automatic int ref_out();
    longint s = 0;
    for (int k = 0; k < TAPS; k++)
      s += longint'(H[(k < NOPS) ? k : TAPS-1-k]) * longint'(hist[k]);
    s = (s + 16384) >>> 15;
    if (s > 32767)  begin sat_hi++; s = 32767;  end
    if (s < -32768) begin sat_lo++; s = -32768; end
    return int'(s);
  endfunction

  function automatic bit exp_ready();
    return m_busy == 0 && (m_phase == 0 || !m_ov);
  endfunction

  // behavioural reference, advanced on every clock edge
  always @(posedge clk) begin
    bit acc;
    if (!rst_n) begin
      for (int k = 0; k < TAPS; k++) hist[k] = 0;
      m_phase = 0; m_busy = 0; m_ov = 0; m_out = 0; m_pend = 0;
    end else begin
      acc = in_valid && exp_ready();
      if (m_ov && out_ready) m_ov = 0;
      if (m_busy > 0) begin
        m_busy--;
        if (m_busy == 0) begin m_ov = 1; m_out = m_pend; end
      end
      if (acc) begin
        for (int k = TAPS-1; k > 0; k--) hist[k] = hist[k-1];
        hist[0] = int'(in_data);
        if (m_phase == 1) begin m_pend = ref_out(); m_busy = NOPS; end
        m_phase ^= 1;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic step();
    bit [31:0] r;
    @(negedge clk);
    if (rst_n) begin
      chk(in_ready === exp_ready(), "R6 in_ready", int'(in_ready), int'(exp_ready()));
      chk(out_valid === m_ov, "R5 out_valid", int'(out_valid), int'(m_ov));
      if (m_ov) chk(int'(out_data) == m_out, "R1 R9 out_data", int'(out_data), m_out);
      if (stall_prev)
        chk(out_valid === 1'b1 && int'(out_data) == stall_data, "R7 hold",
            int'(out_data), stall_data);
    end
    r = rnd();
    out_ready = rdy_mode ? r[3] : 1'b1;
    if (out_valid && out_ready) got.push_back(int'(out_data));
    stall_prev = rst_n && out_valid && !out_ready;
    stall_data = int'(out_data);
  endtask

  task automatic push(input int v);
    bit [31:0] r;
    forever begin
      if (in_ready) begin
        in_valid = 1'b1; in_data = 16'(v);
        step();
        break;
      end else begin
        r = rnd();
        in_valid = r[0]; in_data = r[31:16];   // R9: offered junk while closed
        step();
      end
    end
    in_valid = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; in_valid = 1'b0; stall_prev = 0;
    repeat (3) step();
    rst_n = 1'b1;
    got.delete();
    chk(in_ready === 1'b1, "R8 reset in_ready", int'(in_ready), 1);
    chk(out_valid === 1'b0, "R8 reset out_valid", int'(out_valid), 0);
  endtask

  task automatic drain();
    rdy_mode = 0; in_valid = 1'b0;
    while (m_busy > 0 || m_ov) step();
    step();
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R5 watchdog actual=%0d expected=%0d", 1, 0);
      summary();
      $finish;
    end
  end

  initial begin
    bit [31:0] r;
    int hits_hi, hits_lo;
    // R3 positive tie, R2 count
    do_reset();
    push(0); push(2048);
    repeat (22) push(0);
    drain();
    chk(got.size() == 12, "R2 count", got.size(), 12);
    if (got.size() > 5) chk(got[5] == 1088, "R3 tie up", got[5], 1088);

    // R8: reset midway through a pair, then R3 negative tie
    push(31000); push(-5000); push(777);
    do_reset();
    push(0); push(-2048);
    repeat (22) push(0);
    drain();
    chk(got.size() == 12, "R2 count after reset", got.size(), 12);
    if (got.size() > 5) begin
      chk(got[0] == 4, "R8 first result", got[0], 4);
      chk(got[5] == -1087, "R3 tie down", got[5], -1087);
    end

    // moderate random stream with stalls and gaps
    got.delete();
    rdy_mode = 1;
    for (int i = 0; i < 300; i++) begin
      r = rnd();
      if (r[1:0] == 2'b00) step();
      push(int'($signed(r[31:16])) / 2);
    end

    // full-scale stream for R4
    sat_hi = 0; sat_lo = 0;
    for (int i = 0; i < 400; i++) begin
      r = rnd();
      push(r[5] ? 32767 : -32768);
    end
    drain();
    chk(got.size() == 350, "R2 count stream", got.size(), 350);
    hits_hi = 0; hits_lo = 0;
    foreach (got[i]) begin
      if (got[i] == 32767)  hits_hi++;
      if (got[i] == -32768) hits_lo++;
    end
    chk(sat_hi > 0 && hits_hi >= sat_hi, "R4 upper clamp", hits_hi, sat_hi);
    chk(sat_lo > 0 && hits_lo >= sat_lo, "R4 lower clamp", hits_lo, sat_lo);

    done = 1;
    summary();
    $finish;
  end
endmodule